// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status

This block recovers asynchronous serial words from a single line. The line is brought into the clock domain through a short synchronizer and sampled on an oversampling tick. The tick is taken from a clock divider. A falling edge is only accepted as the start of a word if the line is still low at mid-bit. The data bits are then gathered least significant bit first, and the optional parity bit and the first stop bit are checked.

Each finished word is moved into a single holding register. An eight-bit line status byte reports whether a word is waiting and whether errors occurred. Error flags stay set until the host reads the status byte. The flag that a word is waiting stays set until the host reads the data. Two status bits are not produced here: they repeat the idle flags of a companion transmitter.

The word format uses the same settings as that transmitter: a length of 5 to 8 bits, parity on or off, even or odd parity, and stick parity. A line held low for an entire frame is reported as a break rather than as a framing error. After a break the receiver waits for the line to go high again before it looks for the next word.

Top module: `uart_rx_lsr`

## Requirements
- R1: Word length is set by `wlen_i`: 00=5, 01=6, 10=7, 11=8 data bits, sent least significant bit first. When the first stop bit is sampled, the word is loaded into the holding register. `data_o` shows it right-aligned with the upper bits zero. Status bit 0 (data ready) sets on that load and clears when `rd_data_i` is pulsed.
- R2: If a word completes while status bit 0 is still set, the new word overwrites the held word and status bit 1 (overrun) sets.
- R3: With `par_en_i`=1 a parity bit follows the data. The expected parity bit is set by two inputs. With `par_stick_i`=0, `par_even_i`=1 selects even parity and 0 selects odd parity. With `par_stick_i`=1, the expected bit is the inverse of `par_even_i`. A mismatch sets status bit 2 (parity error).
- R4: If the first stop bit is sampled low and some earlier data or parity bit was high, status bit 3 (framing error) sets. After that, no new start is searched for until the line has been high.
- R5: If the start, data, parity and stop bits are all low, status bit 4 (break) sets, a zero word is loaded, and status bits 2 and 3 are not set by that word. No further word is received while the line stays low.
- R6: A low pulse shorter than half a bit time (8 ticks) is ignored: no word is loaded.
- R7: Status bit 7 sets together with any of status bits 2, 3 or 4 and stays set until the status byte is read.
- R8: A `rd_lsr_i` pulse clears status bits 1 to 4 and bit 7. If a new event happens in the same cycle, the set wins.
- R9: Status bit 6 follows `tx_empty_i` and status bit 5 follows `tx_hold_empty_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| wlen_i | input | 2 | Word length select |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select / inverse stick level |
| par_stick_i | input | 1 | Stick parity |
| tx_empty_i | input | 1 | Transmitter fully idle |
| tx_hold_empty_i | input | 1 | Transmitter holding register free |
| rd_data_i | input | 1 | Host reads the data register (one-cycle pulse) |
| rd_lsr_i | input | 1 | Host reads the status byte (one-cycle pulse) |
| data_o | output | 8 | Holding register |
| lsr_o | output | 8 | Line status byte |

## Verification
The bench builds the block with `CLKS_PER_TICK`=1, so every clock is an oversampling tick and one bit lasts 16 clocks. It uses the default 16x oversampling and a two-stage synchronizer. With this setting the bench can drive every word length and parity mode, framing errors, breaks, overruns and short glitches, bit by bit and with exact timing, in a few thousand cycles. Only the divider count itself stays at its smallest value.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          pe;
    logic          fe;
    logic          bi;
  } rx_word_t;

  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_PE   = 2;
  localparam int LSR_FE   = 3;
  localparam int LSR_BI   = 4;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int LSR_ERR  = 7;
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV = 27
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[0] <= 1'b1;
        else         st_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[g] <= 1'b1;
        else         st_q[g] <= st_q[g-1];
      end
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame import uart_rx_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic [1:0] wlen_i,
  input  logic     par_en_i,
  input  logic     par_even_i,
  input  logic     par_stick_i,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bidx_q;
  logic [DW-1:0] shreg_q;
  logic          any_hi_q;
  logic          par_bad_q;

  logic [2:0]    last_idx;
  logic [DW-1:0] data_al;
  logic          exp_par;
  logic          brk;

  assign last_idx = 3'd4 + {1'b0, wlen_i};
  assign data_al  = shreg_q >> (2'd3 - wlen_i);
  assign exp_par  = par_stick_i ? ~par_even_i
                                : (par_even_i ? ^data_al : ~^data_al);
  assign brk      = !rx_i && !any_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bidx_q    <= '0;
      shreg_q   <= '0;
      any_hi_q  <= 1'b0;
      par_bad_q <= 1'b0;
      done_o    <= 1'b0;
      word_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_i) begin
            state_q <= ST_START;
            cnt_q   <= CW'(1);
          end
          ST_START: begin
            if (rx_i) state_q <= ST_IDLE;          // glitch
            else if (cnt_q == MID) begin
              state_q   <= ST_DATA;
              cnt_q     <= '0;
              bidx_q    <= '0;
              shreg_q   <= '0;
              any_hi_q  <= 1'b0;
              par_bad_q <= 1'b0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q    <= '0;
              shreg_q  <= {rx_i, shreg_q[DW-1:1]};
              any_hi_q <= any_hi_q | rx_i;
              if (bidx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                    bidx_q  <= bidx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q     <= '0;
              any_hi_q  <= any_hi_q | rx_i;
              par_bad_q <= (rx_i != exp_par);
              state_q   <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q       <= '0;
              done_o      <= 1'b1;
              word_o.data <= data_al;
              word_o.bi   <= brk;
              word_o.fe   <= !rx_i && any_hi_q;
              word_o.pe   <= par_en_i && par_bad_q && !brk;
              state_q     <= rx_i ? ST_IDLE : ST_WAIT_HI;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_WAIT_HI: if (rx_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr import uart_rx_pkg::*; #(
  parameter int CLKS_PER_TICK = 27,
  parameter int OSR           = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic [1:0]    wlen_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  input  logic          par_stick_i,
  input  logic          tx_empty_i,
  input  logic          tx_hold_empty_i,
  input  logic          rd_data_i,
  input  logic          rd_lsr_i,
  output logic [DW-1:0] data_o,
  output logic [7:0]    lsr_o
);
  logic     tick;
  logic     rx_s;
  logic     word_done;
  rx_word_t word;

  uart_rx_tick #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s));

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_s),
    .wlen_i(wlen_i), .par_en_i(par_en_i), .par_even_i(par_even_i),
    .par_stick_i(par_stick_i), .done_o(word_done), .word_o(word));

  logic [DW-1:0] hold_q;
  logic dr_q, oe_q, pe_q, fe_q, bi_q, err_q;
  logic oe_set, err_set;

  assign oe_set  = word_done && dr_q && !rd_data_i;
  assign err_set = word_done && (word.pe || word.fe || word.bi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dr_q <= 1'b0; oe_q <= 1'b0; pe_q <= 1'b0;
      fe_q <= 1'b0; bi_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (word_done) hold_q <= word.data;
      // set has priority over the read clear
      dr_q  <= word_done ? 1'b1 : (rd_data_i ? 1'b0 : dr_q);
      oe_q  <= oe_set                 ? 1'b1 : (rd_lsr_i ? 1'b0 : oe_q);
      pe_q  <= (word_done && word.pe) ? 1'b1 : (rd_lsr_i ? 1'b0 : pe_q);
      fe_q  <= (word_done && word.fe) ? 1'b1 : (rd_lsr_i ? 1'b0 : fe_q);
      bi_q  <= (word_done && word.bi) ? 1'b1 : (rd_lsr_i ? 1'b0 : bi_q);
      err_q <= err_set                ? 1'b1 : (rd_lsr_i ? 1'b0 : err_q);
    end
  end

  assign data_o = hold_q;
  always_comb begin
    lsr_o           = '0;
    lsr_o[LSR_DR]   = dr_q;
    lsr_o[LSR_OE]   = oe_q;
    lsr_o[LSR_PE]   = pe_q;
    lsr_o[LSR_FE]   = fe_q;
    lsr_o[LSR_BI]   = bi_q;
    lsr_o[LSR_THRE] = tx_hold_empty_i;
    lsr_o[LSR_TEMT] = tx_empty_i;
    lsr_o[LSR_ERR]  = err_q;
  end
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_data_i,
  input logic       rd_lsr_i,
  input logic [7:0] lsr_o,
  input logic       word_done,
  input logic       word_pe,
  input logic       word_fe,
  input logic       word_bi
);
  p_dr_from_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lsr_o[0]) |-> $past(word_done));

  p_dr_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !word_done) |=> !lsr_o[0]);

  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |=> !word_done);

  p_overrun_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done && lsr_o[0] && !rd_data_i) |=> lsr_o[1]);

  p_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done && word_pe) |=> lsr_o[2]);

  p_brk_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done && word_bi) |-> (!word_fe && !word_pe));

  p_err_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_o[2] || lsr_o[3] || lsr_o[4]) |-> lsr_o[7]);

  p_lsr_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lsr_i && !word_done) |=> (lsr_o[4:1] == 4'b0 && !lsr_o[7]));
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_data_i(rd_data_i), .rd_lsr_i(rd_lsr_i),
  .lsr_o(lsr_o), .word_done(word_done), .word_pe(word.pe),
  .word_fe(word.fe), .word_bi(word.bi));

// File: tb/uart_rx_lsr_tb_top.sv
module uart_rx_lsr_tb_top;
  localparam int BIT = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx = 1'b1;
  logic [1:0] wlen = 2'b11;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic tx_empty = 1'b1, tx_hold_empty = 1'b1;
  logic rd_data = 1'b0, rd_lsr = 1'b0;
  logic [7:0] data_o, lsr_o;

  always #5 clk = ~clk;

  uart_rx_lsr #(.CLKS_PER_TICK(1), .OSR(16), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .wlen_i(wlen),
    .par_en_i(par_en), .par_even_i(par_even), .par_stick_i(par_stick),
    .tx_empty_i(tx_empty), .tx_hold_empty_i(tx_hold_empty),
    .rd_data_i(rd_data), .rd_lsr_i(rd_lsr), .data_o(data_o), .lsr_o(lsr_o));

  typedef struct { logic [7:0] d; logic [7:0] l; string tag; } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic m_dr = 0, m_oe = 0, m_pe = 0, m_fe = 0, m_bi = 0, m_err = 0;
  logic [7:0] m_data = '0;

  function automatic logic [7:0] model_lsr();
    return {m_err, tx_empty, tx_hold_empty, m_bi, m_fe, m_pe, m_oe, m_dr};
  endfunction

  task automatic push_exp(input string tag);
    exp_t e;
    e.d = m_data; e.l = model_lsr(); e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor side: pop and compare against the ports
  task automatic check_next();
    exp_t e;
    e = exp_q.pop_front();
    n_cmp++;
    if (data_o !== e.d || lsr_o !== e.l) begin
      n_bad++;
      $display("FAIL %s: data=%h lsr=%b expected data=%h lsr=%b",
               e.tag, data_o, lsr_o, e.d, e.l);
    end
  endtask

  task automatic expect_now(input string tag);
    push_exp(tag);
    check_next();
  endtask

  task automatic drive_bit(input logic v);
    rx = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic model_word(input logic [7:0] d, input logic pe, input logic fe,
                            input logic bi);
    m_oe  = m_oe | m_dr;
    m_dr  = 1'b1;
    m_data = d;
    m_pe  = m_pe | pe;
    m_fe  = m_fe | fe;
    m_bi  = m_bi | bi;
    m_err = m_err | pe | fe | bi;
  endtask

  // driver: send one frame and push the expected result
  task automatic send_word(input logic [7:0] d, input bit bad_par,
                           input bit stop_lo, input string tag);
    int n;
    logic [7:0] dm;
    logic p;
    n  = 5 + int'(wlen);
    dm = d & 8'((1 << n) - 1);
    p  = par_stick ? ~par_even : (par_even ? ^dm : ~^dm);
    if (bad_par) p = ~p;
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(dm[i]);
    if (par_en) drive_bit(p);
    drive_bit(stop_lo ? 1'b0 : 1'b1);
    model_word(dm, par_en && bad_par, stop_lo, 1'b0);
    if (stop_lo) drive_bit(1'b1);
    push_exp(tag);
  endtask

  task automatic do_rd_data();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
    m_dr = 1'b0;
  endtask

  task automatic do_rd_lsr();
    rd_lsr = 1'b1; @(negedge clk); rd_lsr = 1'b0;
    m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_err = 0;
  endtask

  task automatic read_all();
    do_rd_data();
    do_rd_lsr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R9 reset state");

    send_word(8'hA5, 0, 0, "R1 8-bit no parity"); check_next();
    do_rd_data(); expect_now("R1 data read clears ready");
    do_rd_lsr();

    wlen = 2'b00;
    send_word(8'hFB, 0, 0, "R1 5-bit word"); check_next(); read_all();
    wlen = 2'b10; par_en = 1; par_even = 1;
    send_word(8'h35, 0, 0, "R3 7-bit even parity"); check_next(); read_all();
    wlen = 2'b11; par_even = 0;
    send_word(8'h35, 0, 0, "R3 odd parity"); check_next(); read_all();
    par_stick = 1; par_even = 0;
    send_word(8'h3C, 0, 0, "R3 stick mark"); check_next(); read_all();
    par_even = 1;
    send_word(8'hC3, 0, 0, "R3 stick space"); check_next(); read_all();
    par_stick = 0; par_even = 1;
    send_word(8'h5A, 1, 0, "R3 R7 parity error"); check_next();
    do_rd_lsr(); expect_now("R8 status read clears errors");
    do_rd_data();
    par_en = 0;
    send_word(8'hFF, 0, 1, "R4 R7 framing error"); check_next(); read_all();
    send_word(8'h81, 0, 0, "R4 recovers after framing"); check_next(); read_all();

    // break: the whole frame low
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(1'b0);
    drive_bit(1'b0);
    model_word(8'h00, 1'b0, 1'b0, 1'b1);
    expect_now("R5 R7 break detected");
    read_all();
    repeat (4 * BIT) @(negedge clk);
    expect_now("R5 no word while line stays low");
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);

    send_word(8'h11, 0, 0, "R2 first word"); check_next();
    send_word(8'h22, 0, 0, "R2 overrun keeps new word"); check_next();
    read_all();

    rx = 1'b0; repeat (5) @(negedge clk); rx = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    expect_now("R6 short glitch ignored");
    send_word(8'h6E, 0, 0, "R6 word after glitch"); check_next(); read_all();

    tx_empty = 1'b0; tx_hold_empty = 1'b1; @(negedge clk);
    expect_now("R9 tx flags 01");
    tx_empty = 1'b1; tx_hold_empty = 1'b0; @(negedge clk);
    expect_now("R9 tx flags 10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule